// File: doc/BRIEF.md
# Decimal-Fraction Pulse Rate Divider

This block lowers the rate of a pulse train by a programmable factor between 0.1 and 9.9, in steps of one tenth. The pulse input may be asynchronous to the system clock. It is brought into the clock domain and edge-detected. Each rising edge found there launches a fixed burst of ten single-cycle ticks, so every input pulse counts as ten. A two-digit decimal (BCD) down counter then counts those ticks. Each time it completes a full count of the programmed value, it issues one clock-wide output pulse and reloads.

The divisor comes in as two 4-bit BCD digits: a units digit and a tenths digit. The count per output is ten times the units digit plus the tenths digit, measured in ticks. The clock must run at least ten times faster than the highest input pulse rate, so that one burst ends before the next edge arrives. A new input edge that comes while a burst is still running restarts that burst. The divider has no data path that carries a payload, so it has no valid/ready handshake. Every pin is a plain control or status level, or a single-cycle strobe.

Top module: `tenth_rate_divider`

## Requirements
- R1: `rst` is synchronous and active high. After a reset edge the burst stage is idle, the down counter holds the clamped programmed value, and `pulse_out` is 0 in the cycle that follows.
- R2: `pulse_in` passes through a two-flop synchronizer and a rising-edge detector. A rising edge first sampled at clock edge k puts the first tick in the cycle after edge k+2. A level held high for many cycles starts only one burst.
- R3: Each burst is exactly ten consecutive ticks. A new rising edge that arrives during a burst restarts the burst from its first tick.
- R4: The number of ticks per output pulse is N = 10·`div_units` + `div_tenths`. Bits [3:0] of each digit hold one BCD value, and the units digit is the more significant.
- R5: `pulse_out` goes high for one cycle, in the cycle after the clock edge that ends the N-th tick since the last reload. With N = 10, each isolated input pulse gives exactly one output pulse.
- R6: With N = 1 (divisor 0.1), every tick is a terminal count, so one input pulse gives ten output pulses.
- R7: A programmed value of 00 disables the output. With the counter loaded from 00, no output pulses occur.
- R8: A digit value above 9 is treated as 9 wherever the counter loads it.
- R9: A change to the divisor inputs takes effect at the next reload, either at terminal count or at reset. It never shortens or lengthens the count already under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Pulse train to divide, asynchronous to `clk` |
| div_units | input | 4 | Units digit of the divisor, BCD |
| div_tenths | input | 4 | Tenths digit of the divisor, BCD |
| pulse_out | output | 1 | One-cycle strobe at each terminal count |

## Verification
A rising edge on the input that is first seen at clock edge k drives ticks in the ten cycles after edges k+2 through k+11. The output strobe for a terminal count becomes visible one edge after the cycle of the closing tick. For divisor 1.0 that means after edge k+12. The reference model reproduces these delays from recorded input samples and a count of ticks left in the burst. Its expected output is compared with `pulse_out` on every falling edge, midway between the edges where the design changes. The per-scenario totals of output pulses are checked against N only after a quiet window long enough for the final burst and its strobe to finish.

// File: rtl/tenth_div_pkg.sv
`timescale 1ns/1ps
package tenth_div_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] BCD_MAX = 4'd9;

  // saturate an out-of-range BCD digit to nine
  function automatic logic [DIGIT_W-1:0] bcd_clamp(input logic [DIGIT_W-1:0] d);
    return (d > BCD_MAX) ? BCD_MAX : d;
  endfunction
endpackage

// File: rtl/rd_sync_edge.sv
`timescale 1ns/1ps
module rd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sr_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], async_in};
      last_q <= sr_q[STAGES-1];
    end
  end

  assign rise = sr_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rd_burst_gen.sv
`timescale 1ns/1ps
module rd_burst_gen #(
  parameter int BURST_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic tick
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= IDLE;
    else if (start) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q != IDLE);
endmodule

// File: rtl/rd_bcd_downcount.sv
`timescale 1ns/1ps
module rd_bcd_downcount
  import tenth_div_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic [DIGITS*DIGIT_W-1:0] prog,
  output logic                      at_zero,
  output logic                      strobe
);
  localparam int W = DIGITS * DIGIT_W;

  logic [W-1:0]      cnt_q;
  logic [W-1:0]      cnt_dec;
  logic [W-1:0]      load_val;
  logic [DIGITS-1:0] dzero;
  logic [DIGITS-1:0] borrow;
  logic              at_one;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [DIGIT_W-1:0] cur;
    assign cur      = cnt_q[i*DIGIT_W +: DIGIT_W];
    assign dzero[i] = (cur == '0);
    assign load_val[i*DIGIT_W +: DIGIT_W] = bcd_clamp(prog[i*DIGIT_W +: DIGIT_W]);
    if (i == 0) begin : g_lsd
      assign borrow[i] = 1'b1;
    end else begin : g_upper
      assign borrow[i] = borrow[i-1] & dzero[i-1];
    end
    assign cnt_dec[i*DIGIT_W +: DIGIT_W] =
      !borrow[i] ? cur : (dzero[i] ? BCD_MAX : cur - 1'b1);
  end

  assign at_zero = &dzero;
  assign at_one  = (cnt_q[DIGIT_W-1:0] == 4'd1) & (&dzero[DIGITS-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= load_val;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (tick) begin
        if (at_one || at_zero) begin
          cnt_q  <= load_val;
          strobe <= at_one;
        end else begin
          cnt_q <= cnt_dec;
        end
      end
    end
  end
endmodule

// File: rtl/tenth_rate_divider.sv
`timescale 1ns/1ps
module tenth_rate_divider
  import tenth_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BURST_LEN   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pulse_in,
  input  logic [DIGIT_W-1:0] div_units,
  input  logic [DIGIT_W-1:0] div_tenths,
  output logic               pulse_out
);
  logic rise_w;
  logic tick_w;
  logic zero_w;

  rd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pulse_in), .rise(rise_w)
  );

  rd_burst_gen #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk(clk), .rst(rst), .start(rise_w), .tick(tick_w)
  );

  rd_bcd_downcount #(.DIGITS(2)) u_count (
    .clk(clk), .rst(rst), .tick(tick_w),
    .prog({div_units, div_tenths}),
    .at_zero(zero_w), .strobe(pulse_out)
  );
endmodule

// File: rtl/tenth_rate_divider_chk.sv
`timescale 1ns/1ps
module tenth_rate_divider_chk #(
  parameter int BURST_LEN = 10
) (
  input logic clk,
  input logic rst,
  input logic rise,
  input logic tick,
  input logic cnt_zero,
  input logic pulse_out
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (rise) run_q <= '0;
    else if (tick) run_q <= run_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pulse_out);

  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);

  // R3
  burst_start_chk: assert property (@(posedge clk) disable iff (rst) rise |=> tick);

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q == 8'(BURST_LEN)) |-> !tick);

  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst) pulse_out |-> $past(tick));

  // R7
  zero_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_zero) |=> !pulse_out);
endmodule

bind tenth_rate_divider tenth_rate_divider_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rst(rst), .rise(rise_w), .tick(tick_w),
  .cnt_zero(zero_w), .pulse_out(pulse_out)
);

// File: tb/tenth_rate_divider_tb.sv
`timescale 1ns/1ps
module tenth_rate_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse_in = 1'b0;
  logic [3:0] units = 4'd1;
  logic [3:0] tenths = 4'd0;
  logic       pulse_out;

  int    checks = 0;
  int    errors = 0;
  int    outs = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  tenth_rate_divider dut_i (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .div_units(units), .div_tenths(tenths), .pulse_out(pulse_out)
  );

  // values seen by the design at each rising edge
  logic       s_rst = 1'b1;
  logic       s_in = 1'b0;
  logic [3:0] s_u = 4'd0;
  logic [3:0] s_t = 4'd0;
  always @(posedge clk) begin
    s_rst <= rst; s_in <= pulse_in; s_u <= units; s_t <= tenths;
  end

  function automatic int clampd(input logic [3:0] d);
    return (d > 4'd9) ? 9 : int'(d);
  endfunction

  // behavioural reference
  int  hist[3] = '{0, 0, 0};
  int  left = 0;
  int  rem = 0;
  bit  exp_out = 1'b0;
  always @(negedge clk) begin
    bit rz;
    if (s_rst) begin
      hist = '{0, 0, 0};
      left = 0;
      rem = clampd(s_u) * 10 + clampd(s_t);
      exp_out = 1'b0;
    end else begin
      exp_out = 1'b0;
      if (left > 0) begin
        if (rem <= 1) begin
          exp_out = (rem == 1);
          rem = clampd(s_u) * 10 + clampd(s_t);
        end else begin
          rem = rem - 1;
        end
      end
      rz = (hist[1] != 0) && (hist[2] == 0);
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = int'(s_in);
      left = rz ? 10 : ((left > 0) ? left - 1 : 0);
    end
    checks++;
    if (pulse_out !== exp_out) begin
      errors++;
      $display("FAIL %s: pulse_out=%0b expected %0b at %0t", tag, pulse_out, exp_out, $time);
    end
    if (pulse_out === 1'b1) outs++;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    cyc(1);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    outs = 0;
  endtask

  task automatic pulse(input int width, input int gap);
    pulse_in = 1'b1;
    cyc(width);
    pulse_in = 1'b0;
    cyc(gap);
  endtask

  task automatic total_check(input string t, input int expv);
    cyc(40);
    checks++;
    if (outs != expv) begin
      errors++;
      $display("FAIL %s: output count %0d expected %0d", t, outs, expv);
    end
  endtask

  task automatic scenario(input string t, input logic [3:0] u, input logic [3:0] f,
                          input int n, input int width, input int gap, input int expv);
    tag = t;
    units = u;
    tenths = f;
    do_reset();
    for (int i = 0; i < n; i++) pulse(width, gap);
    total_check(t, expv);
  endtask

  initial begin
    cyc(4);
    // R1: quiet while and just after reset
    tag = "R1";
    rst = 1'b0;
    cyc(3);
    checks++;
    if (pulse_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: pulse_out=%0b expected 0 after reset", pulse_out);
    end

    scenario("R5", 4'd1, 4'd0, 5, 1, 15, 5);
    scenario("R6", 4'd0, 4'd1, 3, 1, 15, 30);
    scenario("R4", 4'd2, 4'd5, 10, 1, 15, 4);
    scenario("R4", 4'd9, 4'd9, 20, 1, 15, 2);
    scenario("R7", 4'd0, 4'd0, 5, 1, 15, 0);
    scenario("R8", 4'd0, 4'hA, 9, 1, 15, 10);
    scenario("R8", 4'hF, 4'd3, 10, 1, 15, 1);
    scenario("R2", 4'd0, 4'd1, 1, 50, 15, 10);
    scenario("R3", 4'd1, 4'd0, 2, 1, 5, 1);

    // R9: divisor change lands at the next reload
    tag = "R9";
    units = 4'd1; tenths = 4'd0;
    do_reset();
    pulse(1, 15);
    units = 4'd0; tenths = 4'd5;
    pulse(1, 15);
    pulse(1, 15);
    total_check("R9", 4);

    // R1: reset in mid-burst aborts the burst
    tag = "R1";
    units = 4'd0; tenths = 4'd1;
    do_reset();
    pulse(1, 4);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    outs = 0;
    total_check("R1", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule